// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Six-Flag Status Word

This block performs one of five two-operand operations on either byte-sized or word-sized data: addition, subtraction, bitwise AND, bitwise OR and bitwise XOR. The caller presents two operands, an operation code and a size select. When the caller asserts the valid strobe, the block stores the result and a six-bit status word on the next clock edge. Both stay unchanged until the next accepted operation.

The status word carries six flags. Carry means an unsigned result did not fit in the selected size, or a borrow for subtraction. Overflow means a signed result did not fit. Sign copies the top bit of the sized result. Zero marks an all-zero result. The nibble carry marks a carry or borrow between bit 3 and bit 4. Parity marks an even number of one bits in the low byte. In byte mode the upper half of each operand is ignored and the upper half of the result reads as zero.

The block is meant to sit behind an instruction decoder as the execution stage for simple arithmetic and logic. The decoder supplies a ready-decoded operation code. Code values outside the five defined operations are treated as no operation.

Top module: `flag_alu`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, `result` and `flags` are both zero.
- R2: Operation codes are 0 = add, 1 = subtract (A minus B), 2 = AND, 3 = OR, 4 = XOR. When `validIn` is high at a rising clock edge with a defined code, `result` and `flags` show that operation's outcome from that edge onward.
- R3: With `wideSel` = 0 only bits 7:0 of each operand take part, every flag is computed for an 8-bit result, and `result[15:8]` is zero. With `wideSel` = 1 the full 16 bits are used.
- R4: For add, carry (CF) is the carry out of the top bit of the selected size; for example, byte 0x71 + 0x99 sets CF. For subtract, CF is set when A is less than B as unsigned numbers (a borrow).
- R5: Overflow (OF) is set when the true two's-complement sum or difference lies outside the signed range of the selected size.
- R6: Sign (SF) equals the top bit of the sized result (bit 7 for byte, bit 15 for word). Zero (ZF) is set exactly when the sized result is zero.
- R7: The nibble-carry flag (AF) is set for add when bits 3:0 of A plus bits 3:0 of B exceed 0xF. For subtract, AF is set when bits 3:0 of A are less than bits 3:0 of B.
- R8: Parity (PF) is set when `result[7:0]` holds an even number of one bits. This holds for word operations too.
- R9: AND, OR and XOR force CF, OF and AF to 0 and set SF, ZF and PF from their result.
- R10: When `validIn` is low, or the code is 5, 6 or 7, `result` and `flags` keep their previous values.
- R11: Flag bit positions are OF = bit 5, SF = bit 4, ZF = bit 3, AF = bit 2, PF = bit 1, CF = bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Accept the presented operation on this edge |
| opSel | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor) |
| wideSel | input | 1 | 0 = byte operation, 1 = word operation |
| opA | input | 16 | First operand (minuend for subtract) |
| opB | input | 16 | Second operand (subtrahend for subtract) |
| result | output | 16 | Registered result |
| flags | output | 6 | Registered status word {OF, SF, ZF, AF, PF, CF} |

## Verification
The hardest cases to reach from the ports are the byte-mode flags. In byte mode, carry, overflow and nibble carry must come from bit 7 and bit 3 even when the upper operand halves hold values that would change a 16-bit sum. Directed byte operations therefore put non-zero garbage in the upper halves right at the signed and unsigned boundaries (0x7F + 1, 0x80 - 1, 0x00 - 0x01, 0x10 - 0x01). A random stream then mixes both sizes, all eight codes and idle cycles. Every clock is compared against a behavioural model that works with plain integer ranges, not carry chains.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int FLAG_W = 6;
  localparam int CF_BIT = 0;
  localparam int PF_BIT = 1;
  localparam int AF_BIT = 2;
  localparam int ZF_BIT = 3;
  localparam int SF_BIT = 4;
  localparam int OF_BIT = 5;

  localparam int OPSEL_W = 3;

  typedef enum logic [OPSEL_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } aluOp_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2
  } logicSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      load;
    logic      subMode;
    logic      logicOp;
    logicSel_e logicSel;
    logic      wide;
  } aluStrobe_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic               validIn,
  input  logic [OPSEL_W-1:0] opSel,
  input  logic               wideSel,
  output aluStrobe_t         strobe
);

  always_comb begin
    strobe          = '0;
    strobe.logicSel = LOG_AND;
    strobe.wide     = wideSel;
    case (opSel)
      OP_ADD: begin
        strobe.load = validIn;
      end
      OP_SUB: begin
        strobe.load    = validIn;
        strobe.subMode = 1'b1;
      end
      OP_AND: begin
        strobe.load     = validIn;
        strobe.logicOp  = 1'b1;
        strobe.logicSel = LOG_AND;
      end
      OP_OR: begin
        strobe.load     = validIn;
        strobe.logicOp  = 1'b1;
        strobe.logicSel = LOG_OR;
      end
      OP_XOR: begin
        strobe.load     = validIn;
        strobe.logicOp  = 1'b1;
        strobe.logicSel = LOG_XOR;
      end
      default: begin
        strobe.load = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluStrobe_t        strobe,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  localparam int UPPER_W = DATA_W - LANE_W;

  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   sumAll;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] rawRes;
  logic [DATA_W-1:0] nextRes;
  logic              laneCarry;
  logic              nibCarry;
  logic              carryOut;
  logic              aMsb;
  logic              bMsb;
  logic              rMsb;
  logic              cfNext;
  logic              ofNext;
  logic              afNext;
  logic              zfNext;
  logic              sfNext;
  logic              pfNext;

  // One shared adder; subtraction is A + ~B + 1
  assign bEff   = strobe.subMode ? ~opB : opB;
  assign sumAll = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, strobe.subMode};

  // Carry into a bit is recovered from the sum and its two inputs
  assign laneCarry = opA[LANE_W] ^ bEff[LANE_W] ^ sumAll[LANE_W];
  assign nibCarry  = opA[NIB_W]  ^ bEff[NIB_W]  ^ sumAll[NIB_W];

  always_comb begin
    case (strobe.logicSel)
      LOG_OR:  logicRes = opA | opB;
      LOG_XOR: logicRes = opA ^ opB;
      default: logicRes = opA & opB;
    endcase
  end

  assign rawRes = strobe.logicOp ? logicRes : sumAll[DATA_W-1:0];

  // Size select: pick the top bit and carry of the active lane
  always_comb begin
    if (strobe.wide) begin
      nextRes  = rawRes;
      carryOut = sumAll[DATA_W];
      aMsb     = opA[DATA_W-1];
      bMsb     = bEff[DATA_W-1];
      rMsb     = rawRes[DATA_W-1];
    end else begin
      nextRes  = {{UPPER_W{1'b0}}, rawRes[LANE_W-1:0]};
      carryOut = laneCarry;
      aMsb     = opA[LANE_W-1];
      bMsb     = bEff[LANE_W-1];
      rMsb     = rawRes[LANE_W-1];
    end
  end

  always_comb begin
    cfNext = 1'b0;
    ofNext = 1'b0;
    afNext = 1'b0;
    if (!strobe.logicOp) begin
      cfNext = carryOut ^ strobe.subMode;
      afNext = nibCarry ^ strobe.subMode;
      ofNext = (aMsb == bMsb) && (rMsb != aMsb);
    end
    sfNext = rMsb;
    zfNext = (nextRes == '0);
    pfNext = ~^nextRes[LANE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      flags  <= '0;
    end else if (strobe.load) begin
      result         <= nextRes;
      flags[OF_BIT]  <= ofNext;
      flags[SF_BIT]  <= sfNext;
      flags[ZF_BIT]  <= zfNext;
      flags[AF_BIT]  <= afNext;
      flags[PF_BIT]  <= pfNext;
      flags[CF_BIT]  <= cfNext;
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [2:0]        opSel,
  input  logic              wideSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [5:0]        flags
);

  aluStrobe_t strobe;

  flag_alu_ctrl ctrl_i (
    .validIn (validIn),
    .opSel   (opSel),
    .wideSel (wideSel),
    .strobe  (strobe)
  );

  flag_alu_dp #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .NIB_W  (NIB_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (result),
    .flags  (flags)
  );

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic [2:0]        opSel,
  input logic              wideSel,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input logic [5:0]        flags
);

  logic accepted;
  logic logicKind;
  assign accepted  = validIn && (opSel <= 3'd4);
  assign logicKind = validIn && (opSel >= 3'd2) && (opSel <= 3'd4);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (result == '0) && (flags == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> $stable(result) && $stable(flags));

  assert_byte_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    accepted && !wideSel |=> result[DATA_W-1:LANE_W] == '0);

  // R4: byte add carry from an unsigned range test
  assert_byte_carry_R4: assert property (@(posedge clk) disable iff (!rstN)
    validIn && opSel == 3'd0 && !wideSel |=>
      flags[0] == (({1'b0, $past(opA[LANE_W-1:0])} + {1'b0, $past(opB[LANE_W-1:0])}) > {1'b0, {LANE_W{1'b1}}}));

  // R4: subtract borrow as an unsigned compare
  assert_sub_borrow_R4: assert property (@(posedge clk) disable iff (!rstN)
    validIn && opSel == 3'd1 && wideSel |=> flags[0] == ($past(opA) < $past(opB)));

  assert_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> flags[3] == (result == '0));

  assert_sign_R6: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> flags[4] == ($past(wideSel) ? result[DATA_W-1] : result[LANE_W-1]));

  assert_parity_R8: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> flags[1] == ~^result[LANE_W-1:0]);

  assert_logic_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    logicKind |=> (flags[5] == 1'b0) && (flags[2] == 1'b0) && (flags[0] == 1'b0));

endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) chk_i (.*);

// File: tb/flag_alu_tb.sv
module flag_alu_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [2:0]  opSel = '0;
  logic        wideSel = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [15:0] result;
  logic [5:0]  flags;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit checking = 1'b0;

  string curReq = "R1";
  string expReq = "R1";
  int    expRes = 0;
  bit [5:0] expFlags = '0;

  always #5 clk = ~clk;

  flag_alu dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .opSel   (opSel),
    .wideSel (wideSel),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .flags   (flags)
  );

  // Behavioural reference using integer ranges
  function automatic void refAlu(input int a, input int b, input int op, input bit wide,
                                 output int res, output bit [5:0] fl);
    int w, mask, aa, bb, sa, sb, sres, smax, smin, cnt;
    bit cf, of, af, sf, zf, pf;
    w = wide ? 16 : 8;
    mask = (1 << w) - 1;
    aa = a & mask;
    bb = b & mask;
    smax = (1 << (w - 1)) - 1;
    smin = -(1 << (w - 1));
    sa = (aa > smax) ? aa - (1 << w) : aa;
    sb = (bb > smax) ? bb - (1 << w) : bb;
    cf = 0; of = 0; af = 0; res = 0;
    case (op)
      0: begin
        res = (aa + bb) & mask;
        cf = (aa + bb) > mask;
        af = ((aa & 15) + (bb & 15)) > 15;
        sres = sa + sb;
        of = (sres > smax) || (sres < smin);
      end
      1: begin
        res = (aa - bb) & mask;
        cf = aa < bb;
        af = (aa & 15) < (bb & 15);
        sres = sa - sb;
        of = (sres > smax) || (sres < smin);
      end
      2: res = aa & bb;
      3: res = aa | bb;
      default: res = aa ^ bb;
    endcase
    sf = ((res >> (w - 1)) & 1) == 1;
    zf = (res == 0);
    cnt = 0;
    for (int i = 0; i < 8; i++) cnt += (res >> i) & 1;
    pf = (cnt % 2) == 0;
    fl = {of, sf, zf, af, pf, cf};
  endfunction

  always @(posedge clk) begin
    int r;
    bit [5:0] f;
    expReq <= curReq;
    if (!rstN) begin
      expRes   <= 0;
      expFlags <= '0;
    end else if (validIn && opSel <= 3'd4) begin
      refAlu(int'(opA), int'(opB), int'(opSel), wideSel, r, f);
      expRes   <= r;
      expFlags <= f;
    end
  end

  always @(negedge clk) begin
    if (checking && !finished) begin
      checks++;
      if (int'(result) != expRes || flags != expFlags) begin
        fails++;
        $display("FAIL %s result=%h expected=%h flags=%b expected=%b",
                 expReq, result, 16'(expRes), flags, expFlags);
      end
    end
  end

  task automatic apply(input int a, input int b, input int op, input bit wide,
                       input bit v, input string req);
    @(negedge clk);
    opA = 16'(a);
    opB = 16'(b);
    opSel = 3'(op);
    wideSel = wide;
    validIn = v;
    curReq = req;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, also driven with busy inputs
    curReq = "R1";
    @(negedge clk);
    opA = 16'hFFFF; opB = 16'h1234; validIn = 1'b1;
    checking = 1'b1;
    repeat (3) @(negedge clk);
    validIn = 1'b0;
    rstN = 1'b1;

    // R4 byte carry, upper garbage (R3)
    apply(16'hAB71, 16'hCD99, 0, 0, 1, "R4 R3 byte add carry");
    apply(16'h007F, 16'h0001, 0, 0, 1, "R5 R7 byte signed overflow");
    apply(16'h55FF, 16'h0001, 0, 0, 1, "R6 R4 byte wrap to zero");
    apply(16'h7FFF, 16'h0001, 0, 1, 1, "R5 R11 word overflow");
    apply(16'hFFFF, 16'h0001, 0, 1, 1, "R4 R6 word carry zero");
    apply(16'h0000, 16'h0001, 1, 1, 1, "R4 R7 word borrow");
    apply(16'hEE00, 16'h9901, 1, 0, 1, "R4 R3 byte borrow");
    apply(16'h0080, 16'h0001, 1, 0, 1, "R5 byte sub overflow");
    apply(16'h0010, 16'h0001, 1, 0, 1, "R7 nibble borrow");
    apply(16'h000F, 16'h0001, 0, 0, 1, "R7 nibble carry");
    apply(16'h1234, 16'h1234, 1, 1, 1, "R6 R2 equal sub");
    apply(16'hF0F0, 16'h0F0F, 2, 1, 1, "R9 and zero");
    apply(16'h8000, 16'h0003, 3, 1, 1, "R9 R8 or word parity low byte");
    apply(16'hA5A5, 16'hA5A5, 4, 0, 1, "R9 xor zero");
    apply(16'hFFFF, 16'h7F80, 4, 1, 1, "R9 R8 xor word");
    apply(16'h0101, 16'h0202, 3, 0, 1, "R8 R2 or byte");
    apply(16'h1111, 16'h2222, 0, 1, 0, "R10 valid low hold");
    apply(16'hFFFF, 16'hFFFF, 5, 1, 1, "R10 code 5 hold");
    apply(16'h0000, 16'h0001, 7, 0, 1, "R10 code 7 hold");
    apply(16'h8000, 16'h8000, 0, 1, 1, "R5 R4 word neg overflow");
    apply(16'h0000, 16'h0000, 6, 1, 1, "R10 code 6 hold");

    // Mixed random stream
    for (int i = 0; i < 400; i++) begin
      apply(int'($urandom() & 32'hFFFF), int'($urandom() & 32'hFFFF),
            int'($urandom() % 8), 1'($urandom()), ($urandom() % 4) != 0,
            "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    apply(0, 0, 0, 0, 0, "R10 idle tail");
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule